// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block computes every processor state change made when control passes into a trap handler. Four request kinds can trigger an entry: a memory-translation fault, a hardware exception, a hardware break, and an external interrupt. For each cycle it looks at the pending requests and at the current program counter, status word and instruction-state flags. From these it picks one winner. One clock later it presents the new program counter, the link register to write together with its value, the new status word, the syndrome delay-slot bit and the branch-target capture.

The pipeline applies these outputs to its own register file and control state. When `ent_vld` is high, the pipeline must also invalidate its load reservation and clear its instruction-state flags. A combinational output tells the pipeline whether an external interrupt could be accepted right now. A second combinational output flags an instruction-state flag combination that is not allowed.

Top module: `exc_entry_seq`

## Requirements
- R1: A memory-translation fault or a hardware exception that is taken sets `pc_o` to `vbase_i + 0x20` and sets status bit 6 (exception in progress) in `msr_o`.
- R2: A taken hardware exception writes link register 17 with `pc_i + 4`.
- R3: While `cfg_exc_en` is low, a hardware exception request is masked. If it is the only request, no entry occurs (`ent_vld`, `link_we`, `esr_we`, `btr_we` and `resv_clr` stay low). If other requests are pending, the next request in priority is taken instead.
- R4: A taken memory-translation fault writes link register 17 with a return address chosen from the flags:
  - with `ds_i` high: `pc_i - 8` if `bimm_i` is high, otherwise `pc_i - 4`;
  - with `ds_i` low: `pc_i - 4` if `imm_i` is high, otherwise `pc_i`.
  All arithmetic wraps modulo 2^32.
- R5: On either exception kind, `esr_we` is high and `esr_ds` equals `ds_i`. `btr_we` is high exactly when `ds_i` was high, and `btr_o` then equals `btgt_i`.
- R6: A taken external interrupt sets `pc_o` to `vbase_i + 0x10`, writes link register 14 with `pc_i`, and clears status bit 4 (interrupt enable).
- R7: A taken break sets `pc_o` to `vbase_i + 0x18`, writes link register 16 with `pc_i`, and sets status bit 5 (break in progress).
- R8: On every entry, status bit 2 (virtual memory) is copied into bit 3 and bit 0 (user mode) is copied into bit 1. Bits 2 and 0 are then cleared. Bits not named in R1, R6, R7 or R8 pass through unchanged.
- R9: On every entry, `resv_clr` and `iflags_clr` pulse high together with `ent_vld`. Both are low in cycles with no entry.
- R10: `irq_ok` is high only when all of these hold: `msr_i` bit 4 is set, bits 5 and 6 are clear, and both `ds_i` and `imm_i` are low. An external interrupt request is taken only while `irq_ok` is high.
- R11: Priority is memory-translation fault, then hardware exception, then break, then external interrupt. Exactly one entry is taken per cycle. All outputs register one cycle after the requests are sampled.
- R12: `flag_err` is high when `imm_i` and `ds_i` are both high, or when `bimm_i` is high while `ds_i` is low.
- R13: After reset, `ent_vld`, `link_we`, `esr_we`, `btr_we`, `resv_clr` and `iflags_clr` are low, and `pc_o` and `msr_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_mmu | input | 1 | Memory-translation fault request |
| req_hwe | input | 1 | Hardware exception request |
| req_brk | input | 1 | Hardware break request |
| req_irq | input | 1 | External interrupt request |
| cfg_exc_en | input | 1 | Hardware exceptions are configured in |
| pc_i | input | 32 | Current program counter |
| msr_i | input | 32 | Current status word |
| ds_i | input | 1 | Current instruction sits in a delay slot |
| imm_i | input | 1 | Immediate prefix pending |
| bimm_i | input | 1 | Branch was preceded by an immediate prefix |
| btgt_i | input | 32 | Pending branch target |
| vbase_i | input | 32 | Vector base address |
| irq_ok | output | 1 | External interrupt acceptable now |
| flag_err | output | 1 | Illegal instruction-state flag combination |
| ent_vld | output | 1 | An entry was taken (one-cycle pulse) |
| pc_o | output | 32 | New program counter |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link register index |
| link_val | output | 32 | Link register value |
| msr_o | output | 32 | New status word |
| esr_we | output | 1 | Syndrome delay-slot bit write enable |
| esr_ds | output | 1 | Syndrome delay-slot bit value |
| btr_we | output | 1 | Branch target register write enable |
| btr_o | output | 32 | Branch target register value |
| resv_clr | output | 1 | Invalidate load reservation |
| iflags_clr | output | 1 | Clear instruction-state flags |

## Verification
The bench targets the four return-address cases of a memory-translation fault, including a fault near address zero. A design that ignored the branch-immediate flag would return into the middle of the prefix pair; one that did not wrap the subtraction would produce a wrong handler return. It sends a hardware exception while exceptions are configured out, both alone and alongside a pending break. A design that did not mask the request would either enter the handler or let the disabled request block the break. It also blocks interrupts through each gating condition and raises all four requests at once. These expose a wrong priority order and an interrupt taken inside a delay slot or while a handler is already running. Random status words catch a mode shift that clears or copies into the wrong bit.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int ADDR_W    = 32;
  localparam int MSR_W     = 32;
  localparam int REG_IDX_W = 5;

  localparam int MSR_UM  = 0;
  localparam int MSR_UMS = 1;
  localparam int MSR_VM  = 2;
  localparam int MSR_VMS = 3;
  localparam int MSR_IE  = 4;
  localparam int MSR_BIP = 5;
  localparam int MSR_EIP = 6;

  localparam logic [ADDR_W-1:0] OFF_IRQ = ADDR_W'(32'h10);
  localparam logic [ADDR_W-1:0] OFF_BRK = ADDR_W'(32'h18);
  localparam logic [ADDR_W-1:0] OFF_EXC = ADDR_W'(32'h20);

  localparam logic [REG_IDX_W-1:0] LNK_EXC = REG_IDX_W'(17);
  localparam logic [REG_IDX_W-1:0] LNK_BRK = REG_IDX_W'(16);
  localparam logic [REG_IDX_W-1:0] LNK_IRQ = REG_IDX_W'(14);

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_MMU  = 3'd1,
    K_HWE  = 3'd2,
    K_BRK  = 3'd3,
    K_IRQ  = 3'd4
  } entry_kind_e;

  // Return address of a translation fault, from delay-slot and prefix state.
  function automatic logic [ADDR_W-1:0] mmu_return(
      input logic [ADDR_W-1:0] pc, input logic ds, input logic imm,
      input logic bimm);
    logic [ADDR_W-1:0] back;
    if (ds)       back = bimm ? ADDR_W'(8) : ADDR_W'(4);
    else if (imm) back = ADDR_W'(4);
    else          back = '0;
    return pc - back;
  endfunction

  // Status word after entry: kind-specific bit, then the mode shift.
  function automatic logic [MSR_W-1:0] msr_on_entry(
      input entry_kind_e kind, input logic [MSR_W-1:0] msr);
    logic [MSR_W-1:0] m;
    logic [MSR_W-1:0] saved;
    m = msr;
    case (kind)
      K_MMU, K_HWE: m[MSR_EIP] = 1'b1;
      K_BRK:        m[MSR_BIP] = 1'b1;
      K_IRQ:        m[MSR_IE]  = 1'b0;
      default:      ;
    endcase
    saved = '0;
    saved[MSR_VMS] = m[MSR_VM];
    saved[MSR_UMS] = m[MSR_UM];
    m[MSR_VMS] = 1'b0;
    m[MSR_UMS] = 1'b0;
    m[MSR_VM]  = 1'b0;
    m[MSR_UM]  = 1'b0;
    return m | saved;
  endfunction

  // Acceptance condition for an external interrupt.
  function automatic logic irq_gate(input logic [MSR_W-1:0] msr,
                                    input logic ds, input logic imm);
    return msr[MSR_IE] & ~msr[MSR_EIP] & ~msr[MSR_BIP] & ~ds & ~imm;
  endfunction
endpackage

// File: rtl/exc_arb.sv
module exc_arb
  import exc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_mmu,
  input  logic             req_hwe,
  input  logic             req_brk,
  input  logic             req_irq,
  input  logic             cfg_exc_en,
  input  logic [MSR_W-1:0] msr_i,
  input  logic             ds_i,
  input  logic             imm_i,
  output logic             irq_ok,
  output entry_kind_e      kind
);
  localparam int NREQ = 4;

  logic [NREQ-1:0] raw;
  logic [NREQ-1:0] grant;

  assign irq_ok = irq_gate(msr_i, ds_i, imm_i);

  // Index order is priority order: 0 is highest.
  assign raw = {req_irq & irq_ok, req_brk, req_hwe & cfg_exc_en, req_mmu};

  always_comb begin
    grant = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (raw[i]) grant = NREQ'(1) << i;
    end
  end

  always_comb begin
    unique case (1'b1)
      grant[0]: kind = K_MMU;
      grant[1]: kind = K_HWE;
      grant[2]: kind = K_BRK;
      grant[3]: kind = K_IRQ;
      default:  kind = K_NONE;
    endcase
  end

  // R11
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3
  hwe_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_HWE) |-> cfg_exc_en);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_IRQ) |-> (msr_i[MSR_IE] && !ds_i && !imm_i && !msr_i[MSR_EIP]
                         && !msr_i[MSR_BIP]));
endmodule

// File: rtl/exc_link.sv
module exc_link
  import exc_seq_pkg::*;
(
  input  entry_kind_e          kind,
  input  logic [ADDR_W-1:0]    pc_i,
  input  logic [ADDR_W-1:0]    vbase_i,
  input  logic                 ds_i,
  input  logic                 imm_i,
  input  logic                 bimm_i,
  output logic [ADDR_W-1:0]    vec_pc,
  output logic [REG_IDX_W-1:0] lnk_idx,
  output logic [ADDR_W-1:0]    lnk_val
);
  always_comb begin
    vec_pc  = pc_i;
    lnk_idx = '0;
    lnk_val = '0;
    case (kind)
      K_MMU: begin
        vec_pc  = vbase_i + OFF_EXC;
        lnk_idx = LNK_EXC;
        lnk_val = mmu_return(pc_i, ds_i, imm_i, bimm_i);
      end
      K_HWE: begin
        vec_pc  = vbase_i + OFF_EXC;
        lnk_idx = LNK_EXC;
        lnk_val = pc_i + ADDR_W'(4);
      end
      K_BRK: begin
        vec_pc  = vbase_i + OFF_BRK;
        lnk_idx = LNK_BRK;
        lnk_val = pc_i;
      end
      K_IRQ: begin
        vec_pc  = vbase_i + OFF_IRQ;
        lnk_idx = LNK_IRQ;
        lnk_val = pc_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_msr.sv
module exc_msr
  import exc_seq_pkg::*;
(
  input  entry_kind_e      kind,
  input  logic [MSR_W-1:0] msr_i,
  output logic [MSR_W-1:0] msr_nx
);
  assign msr_nx = msr_on_entry(kind, msr_i);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_mmu,
  input  logic                 req_hwe,
  input  logic                 req_brk,
  input  logic                 req_irq,
  input  logic                 cfg_exc_en,
  input  logic [ADDR_W-1:0]    pc_i,
  input  logic [MSR_W-1:0]     msr_i,
  input  logic                 ds_i,
  input  logic                 imm_i,
  input  logic                 bimm_i,
  input  logic [ADDR_W-1:0]    btgt_i,
  input  logic [ADDR_W-1:0]    vbase_i,
  output logic                 irq_ok,
  output logic                 flag_err,
  output logic                 ent_vld,
  output logic [ADDR_W-1:0]    pc_o,
  output logic                 link_we,
  output logic [REG_IDX_W-1:0] link_idx,
  output logic [ADDR_W-1:0]    link_val,
  output logic [MSR_W-1:0]     msr_o,
  output logic                 esr_we,
  output logic                 esr_ds,
  output logic                 btr_we,
  output logic [ADDR_W-1:0]    btr_o,
  output logic                 resv_clr,
  output logic                 iflags_clr
);
  entry_kind_e          kind;
  logic [ADDR_W-1:0]    vec_pc;
  logic [REG_IDX_W-1:0] lnk_idx;
  logic [ADDR_W-1:0]    lnk_val;
  logic [MSR_W-1:0]     msr_nx;
  logic                 take;
  logic                 is_exc;

  exc_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .req_mmu(req_mmu), .req_hwe(req_hwe), .req_brk(req_brk),
    .req_irq(req_irq), .cfg_exc_en(cfg_exc_en), .msr_i(msr_i),
    .ds_i(ds_i), .imm_i(imm_i), .irq_ok(irq_ok), .kind(kind)
  );

  exc_link u_link (
    .kind(kind), .pc_i(pc_i), .vbase_i(vbase_i), .ds_i(ds_i),
    .imm_i(imm_i), .bimm_i(bimm_i), .vec_pc(vec_pc),
    .lnk_idx(lnk_idx), .lnk_val(lnk_val)
  );

  exc_msr u_msr (.kind(kind), .msr_i(msr_i), .msr_nx(msr_nx));

  assign take     = (kind != K_NONE);
  assign is_exc   = (kind == K_MMU) || (kind == K_HWE);
  assign flag_err = (imm_i & ds_i) | (bimm_i & ~ds_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld    <= 1'b0;
      pc_o       <= '0;
      link_we    <= 1'b0;
      link_idx   <= '0;
      link_val   <= '0;
      msr_o      <= '0;
      esr_we     <= 1'b0;
      esr_ds     <= 1'b0;
      btr_we     <= 1'b0;
      btr_o      <= '0;
      resv_clr   <= 1'b0;
      iflags_clr <= 1'b0;
    end else begin
      ent_vld    <= take;
      link_we    <= take;
      resv_clr   <= take;
      iflags_clr <= take;
      esr_we     <= is_exc;
      btr_we     <= is_exc & ds_i;
      if (take) begin
        pc_o     <= vec_pc;
        link_idx <= lnk_idx;
        link_val <= lnk_val;
        msr_o    <= msr_nx;
      end
      if (is_exc) esr_ds <= ds_i;
      if (is_exc && ds_i) btr_o <= btgt_i;
    end
  end

  // R1
  mmu_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_mmu |=> (ent_vld && pc_o == $past(vbase_i) + OFF_EXC && msr_o[MSR_EIP]));

  // R3
  hwe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hwe && !cfg_exc_en && !req_mmu && !req_brk && !req_irq) |=> !ent_vld);

  // R6
  irq_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_irq && irq_ok && !req_mmu && !req_brk && !(req_hwe && cfg_exc_en))
      |=> (link_idx == LNK_IRQ && !msr_o[MSR_IE] && link_val == $past(pc_i)));

  // R8
  mode_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_mmu |=> (msr_o[MSR_VMS] == $past(msr_i[MSR_VM]) &&
                 msr_o[MSR_UMS] == $past(msr_i[MSR_UM]) &&
                 !msr_o[MSR_VM] && !msr_o[MSR_UM]));

  // R9
  side_effects_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_vld |-> (resv_clr && iflags_clr && link_we));

  // R5
  btr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mmu && ds_i) |=> (btr_we && esr_ds && btr_o == $past(btgt_i)));
endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_mmu, req_hwe, req_brk, req_irq, cfg_exc_en;
  logic [31:0] pc_i, msr_i, btgt_i, vbase_i;
  logic        ds_i, imm_i, bimm_i;
  logic        irq_ok, flag_err, ent_vld, link_we, esr_we, esr_ds, btr_we;
  logic        resv_clr, iflags_clr;
  logic [31:0] pc_o, link_val, msr_o, btr_o;
  logic [4:0]  link_idx;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  exc_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .req_mmu(req_mmu), .req_hwe(req_hwe),
    .req_brk(req_brk), .req_irq(req_irq), .cfg_exc_en(cfg_exc_en),
    .pc_i(pc_i), .msr_i(msr_i), .ds_i(ds_i), .imm_i(imm_i), .bimm_i(bimm_i),
    .btgt_i(btgt_i), .vbase_i(vbase_i), .irq_ok(irq_ok), .flag_err(flag_err),
    .ent_vld(ent_vld), .pc_o(pc_o), .link_we(link_we), .link_idx(link_idx),
    .link_val(link_val), .msr_o(msr_o), .esr_we(esr_we), .esr_ds(esr_ds),
    .btr_we(btr_we), .btr_o(btr_o), .resv_clr(resv_clr), .iflags_clr(iflags_clr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: got cyc=%0d exp<=100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Bench model: 0 none, 1 mmu, 2 hwe, 3 brk, 4 irq
  function automatic logic m_irq_ok(logic [31:0] m, logic ds, logic imm);
    return (m[4] == 1'b1) && (m[6:5] == 2'b00) && !ds && !imm;
  endfunction

  function automatic int m_pick();
    if (req_mmu) return 1;
    if (req_hwe && cfg_exc_en) return 2;
    if (req_brk) return 3;
    if (req_irq && m_irq_ok(msr_i, ds_i, imm_i)) return 4;
    return 0;
  endfunction

  function automatic logic [31:0] m_msr(int k, logic [31:0] m);
    logic [31:0] r;
    r = m & ~32'h0000_000F;
    if (k == 1 || k == 2) r = r | 32'h40;
    if (k == 3) r = r | 32'h20;
    if (k == 4) r = r & ~32'h10;
    r = r | {28'd0, m[2], 1'b0, m[0], 1'b0};
    return r;
  endfunction

  function automatic logic [31:0] m_link(int k);
    case (k)
      1: begin
        if (ds_i && bimm_i) return pc_i + 32'hFFFF_FFF8;
        if (ds_i || imm_i) return pc_i + 32'hFFFF_FFFC;
        return pc_i;
      end
      2: return pc_i + 32'd4;
      default: return pc_i;
    endcase
  endfunction

  // Drive at negedge, sample combinational at once, registered at next negedge.
  task automatic step();
    int k;
    logic [31:0] e_pc, e_lnk, e_msr, tgt;
    logic [4:0]  e_idx;
    logic        ds_s;
    k = m_pick();
    #1;
    chk("R10 irq_ok", {31'd0, irq_ok}, {31'd0, m_irq_ok(msr_i, ds_i, imm_i)});
    chk("R12 flag_err", {31'd0, flag_err},
        {31'd0, (ds_i && imm_i) || (bimm_i && !ds_i)});
    e_pc  = (k == 4) ? vbase_i + 32'h10 : (k == 3) ? vbase_i + 32'h18 : vbase_i + 32'h20;
    e_idx = (k == 4) ? 5'd14 : (k == 3) ? 5'd16 : 5'd17;
    e_lnk = m_link(k);
    e_msr = m_msr(k, msr_i);
    tgt   = btgt_i;
    ds_s  = ds_i;
    @(negedge clk);
    chk("R11 ent_vld", {31'd0, ent_vld}, {31'd0, k != 0});
    chk("R9 resv_clr", {31'd0, resv_clr}, {31'd0, k != 0});
    chk("R9 iflags_clr", {31'd0, iflags_clr}, {31'd0, k != 0});
    chk("R5 esr_we", {31'd0, esr_we}, {31'd0, k == 1 || k == 2});
    chk("R5 btr_we", {31'd0, btr_we}, {31'd0, (k == 1 || k == 2) && ds_s});
    if (k != 0) begin
      chk(k == 4 ? "R6 pc" : k == 3 ? "R7 pc" : "R1 pc", pc_o, e_pc);
      chk("R11 link_idx", {27'd0, link_idx}, {27'd0, e_idx});
      chk(k == 1 ? "R4 link" : k == 2 ? "R2 link" : "R6/R7 link", link_val, e_lnk);
      chk("R8 msr", msr_o, e_msr);
    end
    if (k == 1 || k == 2) begin
      chk("R5 esr_ds", {31'd0, esr_ds}, {31'd0, ds_s});
      if (ds_s) chk("R5 btr", btr_o, tgt);
    end
  endtask

  task automatic set_in(logic m, logic h, logic b, logic i, logic en,
                        logic [31:0] pc, logic [31:0] ms, logic ds, logic imm,
                        logic bi);
    req_mmu = m; req_hwe = h; req_brk = b; req_irq = i; cfg_exc_en = en;
    pc_i = pc; msr_i = ms; ds_i = ds; imm_i = imm; bimm_i = bi;
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_1234);
    rst_n = 1'b0;
    set_in(0, 0, 0, 0, 1, 32'h0, 32'h0, 0, 0, 0);
    btgt_i = 32'hCAFE_0000; vbase_i = 32'h0000_1000;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 ent_vld", {31'd0, ent_vld}, 32'd0);
    chk("R13 link_we", {31'd0, link_we}, 32'd0);
    chk("R13 btr_we", {31'd0, btr_we}, 32'd0);
    chk("R13 pc_o", pc_o, 32'd0);
    chk("R13 msr_o", msr_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 directed: four return-address cases, including wrap near zero
    set_in(1, 0, 0, 0, 1, 32'h0000_0004, 32'h5, 1, 0, 1); step();
    set_in(1, 0, 0, 0, 1, 32'h0000_2000, 32'h5, 1, 0, 0); step();
    set_in(1, 0, 0, 0, 1, 32'h0000_2000, 32'h0, 0, 1, 0); step();
    set_in(1, 0, 0, 0, 1, 32'h0000_2000, 32'h4, 0, 0, 0); step();
    // R3 disabled hardware exception alone, then with a break pending
    set_in(0, 1, 0, 0, 0, 32'h300, 32'h10, 0, 0, 0); step();
    set_in(0, 1, 1, 0, 0, 32'h300, 32'h10, 0, 0, 0); step();
    // R2 enabled hardware exception in delay slot
    set_in(0, 1, 0, 0, 1, 32'h400, 32'h7, 1, 0, 0); step();
    // R11 everything at once
    set_in(1, 1, 1, 1, 1, 32'h500, 32'h15, 0, 0, 0); step();
    // R10 interrupt blocked by each condition, then accepted
    set_in(0, 0, 0, 1, 1, 32'h600, 32'h50, 0, 0, 0); step();
    set_in(0, 0, 0, 1, 1, 32'h600, 32'h30, 0, 0, 0); step();
    set_in(0, 0, 0, 1, 1, 32'h600, 32'h10, 1, 0, 0); step();
    set_in(0, 0, 0, 1, 1, 32'h600, 32'h10, 0, 1, 0); step();
    set_in(0, 0, 0, 1, 1, 32'h600, 32'h00, 0, 0, 0); step();
    set_in(0, 0, 0, 1, 1, 32'h600, 32'h15, 0, 0, 0); step();
    // R7 break
    set_in(0, 0, 1, 0, 1, 32'h700, 32'h5, 0, 0, 0); step();

    // Random stimulus
    for (int n = 0; n < 600; n++) begin
      req_mmu    = ($urandom_range(0, 5) == 0);
      req_hwe    = ($urandom_range(0, 4) == 0);
      req_brk    = ($urandom_range(0, 4) == 0);
      req_irq    = ($urandom_range(0, 1) == 0);
      cfg_exc_en = ($urandom_range(0, 3) != 0);
      pc_i       = $urandom();
      msr_i      = $urandom();
      if ($urandom_range(0, 1) == 0) msr_i[6:4] = 3'b001;
      ds_i       = $urandom_range(0, 1);
      imm_i      = ($urandom_range(0, 3) == 0);
      bimm_i     = $urandom_range(0, 1);
      btgt_i     = $urandom();
      vbase_i    = $urandom();
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule